// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Register

This block is the execute stage arithmetic and logic unit of a small 8-bit RISC core. One operand byte comes from a working register. The second operand byte is either another register or an immediate, and the unit does not distinguish between the two. A 5-bit operation code chooses the function. The result byte is produced combinationally in the same cycle. `wr_o` tells the register file whether that result is to be written back.

The eight condition flags are held in a status register inside the block. The carry used by the carry-chained operations is read from that register. On each clock edge with `en_i` high, the flags are updated. Each operation changes only its own subset of flags, so flags left by earlier instructions survive into later ones. Multi-byte adds, subtracts and compares are built by chaining operations through the carry and zero flags.

Status bit positions (bit 7 down to bit 0): I, T, H, S, V, N, Z, C.

Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CP, 5 CPC, 6 AND, 7 OR, 8 XOR, 9 COM, 10 NEG, 11 INC, 12 DEC, 13 LSL, 14 LSR, 15 ROL, 16 ROR, 17 ASR, 18 SWAP, 19 BSET, 20 BCLR, 21 NOP. Codes 22 to 31 behave as NOP.

Top module: `alu8_core`

## Requirements
- R1: After a synchronous active-low reset, `sreg_o` is 0x00.
- R2: ADD (0), ADC (1), SUB (2), SBC (3) and NEG (10) produce the following results:
  - ADD: a+b.
  - ADC: a+b+C.
  - SUB: a−b.
  - SBC: a−b−C.
  - NEG: 0x00−a.
  
  The results are taken modulo 256. These operations set H from the carry or borrow at the nibble boundary, C from the carry or borrow out of bit 7, V from two's-complement overflow, N from bit 7 and Z from a zero result. Bits I and T keep their values.
- R3: For SBC (3) and CPC (5), Z becomes 1 only if the result is zero and Z was already 1. Otherwise Z is cleared.
- R4: CP (4) and CPC (5) update the flags exactly as SUB and SBC do, but hold `wr_o` low.
- R5: AND (6), OR (7), XOR (8), INC (11) and DEC (12) update only Z, N, V and S. V is 0, except that INC of 0x7F sets V and DEC of 0x80 sets V. C and H keep their values.
- R6: COM (9) gives 0xFF−a. It sets C to 1, clears V, and sets Z and N from the result.
- R7: The shift operations produce the following results:
  - LSL (13): {a[6:0],0}.
  - LSR (14): {0,a[7:1]}.
  - ROL (15): {a[6:0],C}.
  - ROR (16): {C,a[7:1]}.
  - ASR (17): {a[7],a[7:1]}.
  
  For each of them, C takes the bit shifted out, N and Z follow the result, V = N xor C, and H is unchanged.
- R8: SWAP (18) gives {a[3:0],a[7:4]} and leaves all eight flags unchanged.
- R9: BSET (19) sets status bit `fsel_i` to 1, and BCLR (20) clears that bit. Neither touches any other bit, and both hold `wr_o` low.
- R10: After any operation that writes N or V, S equals N xor V.
- R11: With `en_i` low, or for NOP or unused codes, `sreg_o` does not change and `wr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Execute this cycle: flags update at the edge |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | First operand (destination register value) |
| opb_i | input | 8 | Second operand (register or immediate) |
| fsel_i | input | 3 | Status bit index for BSET and BCLR |
| result_o | output | 8 | Result byte (combinational) |
| wr_o | output | 1 | Result is to be written back |
| sreg_o | output | 8 | Status register |

## Verification
The embedded assertions check several rules on every executed cycle:
- the S = N xor V rule;
- the stickiness of Z under carry-chained subtracts;
- carry and half-carry being preserved by logic, increment and decrement;
- the forced flag values of COM;
- SWAP leaving the flags untouched;
- the write-enable suppression for compares and flag operations;
- the single-bit effect of BSET and BCLR.

The numeric correctness of the following can only be shown by the bench's scenarios, which compare every result and flag against a bench model over random and directed operands:
- results, carries and half-carries;
- overflow detection at the 0x7F and 0x80 boundaries;
- multi-byte chains.

// File: rtl/alu8_pkg.sv
// Package: shared widths, operation codes and status bit positions for the
// byte ALU. Assumes an 8-bit datapath with the half-carry at the nibble edge.
package alu8_pkg;
    localparam int DW   = 8;
    localparam int OPW  = 5;
    localparam int SELW = 3;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_BSET = 5'd19,
        OP_BCLR = 5'd20, OP_NOP  = 5'd21
    } alu_op_e;

    // Status bit positions
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;
    localparam int FT = 6;
    localparam int FI = 7;
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor: computes a+b+cin or a-b-cin and returns the carry or
// borrow out of the top bit, the carry or borrow across the nibble boundary,
// and the signed overflow. Assumes W is even.
module alu8_addsub #(
    parameter int W = alu8_pkg::DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c,
    output logic         h,
    output logic         v
);
    localparam int HW = W / 2;

    logic [W:0]  full;
    logic [HW:0] low;

    // Full-width and lower-nibble sums or differences
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        end
    end

    // Result, carry or borrow, and signed overflow
    always_comb begin
        res = full[W-1:0];
        c   = full[W];
        h   = low[HW];
        if (sub)
            v = (a[W-1] & ~b[W-1] & ~res[W-1]) | (~a[W-1] & b[W-1] & res[W-1]);
        else
            v = (a[W-1] & b[W-1] & ~res[W-1]) | (~a[W-1] & ~b[W-1] & res[W-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
// Bitwise, increment, decrement, complement, shift, rotate and swap unit.
// Returns the result plus the carry and overflow that these operations
// define. Carry and overflow are don't-care for operations that keep them.
module alu8_bitops #(
    parameter int W = alu8_pkg::DW
) (
    input  alu8_pkg::alu_op_e op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic              cin,
    output logic [W-1:0]      res,
    output logic              c,
    output logic              v
);
    import alu8_pkg::*;
    localparam int HW = W / 2;
    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

    // Per-operation result, carry and overflow
    always_comb begin
        res = a;
        c   = cin;
        v   = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  begin res = ~a; c = 1'b1; end
            OP_INC:  begin res = a + ONE; v = (a == MAXPOS); end
            OP_DEC:  begin res = a - ONE; v = (a == MINNEG); end
            OP_LSL:  begin res = {a[W-2:0], 1'b0};   c = a[W-1]; v = res[W-1] ^ c; end
            OP_ROL:  begin res = {a[W-2:0], cin};    c = a[W-1]; v = res[W-1] ^ c; end
            OP_LSR:  begin res = {1'b0, a[W-1:1]};   c = a[0];   v = res[W-1] ^ c; end
            OP_ROR:  begin res = {cin, a[W-1:1]};    c = a[0];   v = res[W-1] ^ c; end
            OP_ASR:  begin res = {a[W-1], a[W-1:1]}; c = a[0];   v = res[W-1] ^ c; end
            OP_SWAP: res = {a[HW-1:0], a[W-1:HW]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
// Top: byte ALU with its status register. Picks the arithmetic or bitwise
// unit, computes the next flags for the selected flag subset, and holds the
// status byte. Assumes the register file gates its write with wr_o.
module alu8_core #(
    parameter int W    = alu8_pkg::DW,
    parameter int SELW = alu8_pkg::SELW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic [alu8_pkg::OPW-1:0]   op_i,
    input  logic [W-1:0]               opa_i,
    input  logic [W-1:0]               opb_i,
    input  logic [SELW-1:0]            fsel_i,
    output logic [W-1:0]               result_o,
    output logic                       wr_o,
    output logic [7:0]                 sreg_o
);
    import alu8_pkg::*;

    alu_op_e      op;
    logic [7:0]   sreg_q, sreg_d;
    logic [W-1:0] as_a, as_b, as_res, bo_res;
    logic         as_cin, as_sub, as_c, as_h, as_v, bo_c, bo_v;
    logic         is_arith, is_logic, is_cshift, zero, writes;

    assign op = alu_op_e'(op_i);

    // Operand routing into the adder/subtractor
    always_comb begin
        as_a   = (op == OP_NEG) ? '0 : opa_i;
        as_b   = (op == OP_NEG) ? opa_i : opb_i;
        as_sub = op inside {OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG};
        as_cin = (op inside {OP_ADC, OP_SBC, OP_CPC}) ? sreg_q[FC] : 1'b0;
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .res(as_res), .c(as_c), .h(as_h), .v(as_v)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op(op), .a(opa_i), .b(opb_i), .cin(sreg_q[FC]),
        .res(bo_res), .c(bo_c), .v(bo_v)
    );

    // Operation classes and result selection
    always_comb begin
        is_arith  = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG};
        is_logic  = op inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC};
        is_cshift = op inside {OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR};
        writes    = is_arith | is_logic | is_cshift | (op == OP_SWAP);
        if (op inside {OP_CP, OP_CPC}) writes = 1'b0;
        result_o  = is_arith ? as_res : bo_res;
        zero      = (result_o == '0);
        wr_o      = en_i & writes;
    end

    // Next status byte: only the flag subset of the operation changes
    always_comb begin
        sreg_d = sreg_q;
        if (is_arith) begin
            sreg_d[FZ] = (op inside {OP_SBC, OP_CPC}) ? (zero & sreg_q[FZ]) : zero;
            sreg_d[FC] = as_c;
            sreg_d[FH] = as_h;
            sreg_d[FV] = as_v;
            sreg_d[FN] = result_o[W-1];
            sreg_d[FS] = result_o[W-1] ^ as_v;
        end else if (is_logic || is_cshift) begin
            sreg_d[FZ] = zero;
            sreg_d[FV] = bo_v;
            sreg_d[FN] = result_o[W-1];
            sreg_d[FS] = result_o[W-1] ^ bo_v;
            if (is_cshift) sreg_d[FC] = bo_c;
        end else if (op == OP_BSET) begin
            sreg_d[fsel_i] = 1'b1;
        end else if (op == OP_BCLR) begin
            sreg_d[fsel_i] = 1'b0;
        end
    end

    // Status register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)    sreg_q <= '0;
        else if (en_i) sreg_q <= sreg_d;
    end

    assign sreg_o = sreg_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> sreg_o == 8'h00); // R1
    AST_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && (op inside {OP_SBC, OP_CPC}) && !sreg_q[FZ] |=> !sreg_q[FZ]); // R3
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_CP, OP_CPC, OP_BSET, OP_BCLR}) |-> !wr_o); // R4
    AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_logic |=> $stable(sreg_q[FC]) && $stable(sreg_q[FH])); // R5
    AST_COM_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && op == OP_COM |=> sreg_q[FC] && !sreg_q[FV]); // R6
    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && op == OP_SWAP |=> $stable(sreg_q)); // R8
    AST_FLAG_OP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && (op inside {OP_BSET, OP_BCLR}) |=> $countones(sreg_q ^ $past(sreg_q)) <= 1); // R9
    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && (is_arith || is_logic || is_cshift) |=> sreg_q[FS] == (sreg_q[FN] ^ sreg_q[FV])); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(sreg_q)); // R11
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] op_i = 5'd21;
    logic [7:0] opa_i = '0, opb_i = '0;
    logic [2:0] fsel_i = '0;
    logic [7:0] result_o, sreg_o;
    logic       wr_o;

    int checks = 0, fails = 0;
    logic [7:0] m_sreg;

    always #2 clk = ~clk;

    alu8_core u_dut (.clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .fsel_i(fsel_i),
        .result_o(result_o), .wr_o(wr_o), .sreg_o(sreg_o));

    function automatic string req_of(input int op);
        if (op <= 2 || op == 10) return "R2";
        if (op == 3 || op == 5)  return "R3";
        if (op == 4)             return "R4";
        if (op == 9)             return "R6";
        if (op >= 6 && op <= 12) return "R5";
        if (op >= 13 && op <= 17) return "R7";
        if (op == 18)            return "R8";
        if (op == 19 || op == 20) return "R9";
        return "R11";
    endfunction

    // Bench model: returns {write, result, next status}
    function automatic logic [16:0] model(input int op, input logic [7:0] a, b,
                                          input logic [2:0] sel, input logic [7:0] s);
        logic [7:0] r = a, ns = s;
        logic w = 1'b0, cy = s[0];
        int x, y, ci;
        ci = 0;
        if (op inside {1, 3, 5}) ci = int'(cy);
        case (op)
            0, 1, 2, 3, 4, 5, 10: begin
                x = (op == 10) ? 0 : int'(a);
                y = (op == 10) ? int'(a) : int'(b);
                if (op inside {0, 1}) begin
                    r = 8'(x + y + ci);
                    ns[0] = (x + y + ci) > 255;
                    ns[5] = ((x % 16) + (y % 16) + ci) > 15;
                    ns[3] = (x[7] == y[7]) && (r[7] != x[7]);
                end else begin
                    r = 8'(x - y - ci);
                    ns[0] = (x - y - ci) < 0;
                    ns[5] = ((x % 16) - (y % 16) - ci) < 0;
                    ns[3] = (x[7] != y[7]) && (r[7] != x[7]);
                end
                ns[1] = (op inside {3, 5}) ? ((r == 0) && s[1]) : (r == 0);
                w = !(op inside {4, 5});
            end
            6: r = a & b;
            7: r = a | b;
            8: r = a ^ b;
            9: begin r = 8'hFF - a; ns[0] = 1'b1; end
            11: r = a + 8'd1;
            12: r = a - 8'd1;
            13: begin r = a << 1; ns[0] = a[7]; end
            14: begin r = a >> 1; ns[0] = a[0]; end
            15: begin r = {a[6:0], cy}; ns[0] = a[7]; end
            16: begin r = {cy, a[7:1]}; ns[0] = a[0]; end
            17: begin r = {a[7], a[7:1]}; ns[0] = a[0]; end
            18: begin r = {a[3:0], a[7:4]}; w = 1'b1; end
            19: ns[sel] = 1'b1;
            20: ns[sel] = 1'b0;
            default: ;
        endcase
        if (op >= 6 && op <= 17 && op != 10) begin
            w = 1'b1;
            ns[1] = (r == 0);
            ns[3] = (op == 11) ? (a == 8'h7F) : (op == 12) ? (a == 8'h80) :
                    (op >= 13) ? (r[7] ^ ns[0]) : 1'b0;
        end
        if ((op >= 0 && op <= 17)) begin
            ns[2] = r[7];
            ns[4] = r[7] ^ ns[3];
        end
        return {w, r, ns};
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic step(input int op, input logic [7:0] a, b, input logic [2:0] sel, input logic en);
        logic [16:0] m;
        @(negedge clk);
        op_i = 5'(op); opa_i = a; opb_i = b; fsel_i = sel; en_i = en;
        m = model(op, a, b, sel, m_sreg);
        #1;
        check(en ? req_of(op) : "R11", "wr", {7'd0, wr_o}, {7'd0, m[16] & en});
        if (m[16]) check(req_of(op), "result", result_o, m[15:8]);
        @(negedge clk);
        en_i = 1'b0;
        if (en) m_sreg = m[7:0];
        check(en ? req_of(op) : "R11", "sreg", sreg_o, m_sreg);
        if (en && op <= 17) check("R10", "S rule", {7'd0, sreg_o[4]}, {7'd0, sreg_o[2] ^ sreg_o[3]});
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_sreg = 8'h00;
        @(negedge clk);
        check("R1", "reset sreg", sreg_o, 8'h00);
        // Directed corner cases
        step(0, 8'h0F, 8'h01, 0, 1);   // R2 half carry
        step(0, 8'h7F, 8'h01, 0, 1);   // R2 overflow
        step(0, 8'hFF, 8'h01, 0, 1);   // R2 carry and zero
        step(10, 8'h80, 8'h00, 0, 1);  // R2 negate min
        step(2, 8'h00, 8'h00, 0, 1);   // sets Z, clears C
        step(3, 8'h05, 8'h05, 0, 1);   // R3 zero result keeps Z
        step(19, 0, 0, 3'd0, 1);       // R9 set C
        step(5, 8'h12, 8'h11, 0, 1);   // R3 zero result keeps Z with borrow
        step(5, 8'h12, 8'h10, 0, 1);   // R3 nonzero clears Z
        step(5, 8'h00, 8'h00, 0, 1);   // R3 Z stays clear
        step(4, 8'h10, 8'h20, 0, 1);   // R4 no write
        step(11, 8'h7F, 0, 0, 1);      // R5 V on 0x7F
        step(12, 8'h80, 0, 0, 1);      // R5 V on 0x80
        step(6, 8'hF0, 8'h0F, 0, 1);   // R5 zero
        step(9, 8'h00, 0, 0, 1);       // R6
        step(17, 8'h81, 0, 0, 1);      // R7 keep bit 7
        step(15, 8'h80, 0, 0, 1);      // R7 rotate
        step(16, 8'h01, 0, 0, 1);      // R7 rotate
        step(18, 8'hA5, 0, 0, 1);      // R8
        step(19, 0, 0, 3'd7, 1);       // R9 I
        step(20, 0, 0, 3'd7, 1);       // R9 clear I
        step(21, 8'h55, 8'h55, 0, 1);  // R11 NOP
        step(0, 8'h80, 8'h80, 0, 0);   // R11 disabled
        // Random operations
        for (int i = 0; i < 3000; i++) begin
            step(int'($urandom_range(0, 23)), 8'($urandom), 8'($urandom),
                 3'($urandom), ($urandom_range(0, 7) != 0));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule